// File: doc/BRIEF.md
# Pipeline Stall and Flush Controller

This block holds the front of a five-stage in-order integer pipeline (fetch, decode, execute, memory, write-back) when there are no bypass paths. It is purely combinational. Each cycle it compares the source registers of the instruction sitting in decode against the destination registers of the two older instructions in execute and memory. If a source is still waiting on one of them, it freezes the program counter and the fetch/decode register, and it loads a no-op into the decode/execute register.

The register file is write-first: a value written in write-back can be read by decode in the same cycle. An instruction in write-back therefore never causes a hold. A consumer right behind its producer waits two cycles. A consumer with one unrelated instruction in between waits one cycle.

Branches compare a register against zero and compute their target in decode. When a branch there is taken and its operand is ready, the block squashes the one instruction fetched behind it. While the branch is still waiting on its operand, its outcome is ignored.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: When an in-use decode source equals the execute-stage destination, and that destination is write-enabled and nonzero, the outputs must be pc_write=0, ifid_write=0 and idex_bubble=1.
- R2: The same hold applies when the matching live writer is in the memory stage instead of execute.
- R3: A producer whose destination is register 0 never causes a hold, even when its write-enable is set and the addresses match.
- R4: A producer with its write-enable clear never causes a hold. A source whose use flag is clear never causes a hold. Source slot 0 is the first operand (base register or tested register); slot 1 is the second operand (store data or second ALU operand).
- R5: A consumer directly behind its producer is held for exactly 2 cycles. A consumer with one unrelated instruction between it and its producer is held for exactly 1 cycle.
- R6: With no hold, a taken branch in decode gives ifid_flush=1, pc_write=1, ifid_write=1 and idex_bubble=0.
- R7: While a hold is active, the branch outcome is ignored and ifid_flush stays 0.
- R8: ifid_flush is 0 whenever the decode instruction is not a branch or its outcome is not-taken.
- R9: With no hold and no taken branch, the outputs must be pc_write=1, ifid_write=1, idex_bubble=0 and ifid_flush=0.
- R10: The six-instruction loop (load, increment, store, pointer add, subtract, branch-if-nonzero) takes 15 cycles per taken iteration. Each iteration has 8 bubble cycles and one flush, except the final not-taken pass, which has no flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_src_addr | input | NUM_SRC*REG_AW | Source register addresses of the decode instruction, one per slot |
| id_src_use | input | NUM_SRC | Per-slot flag: the slot is actually read |
| id_is_branch | input | 1 | Decode instruction is a conditional branch |
| id_br_taken | input | 1 | Branch condition evaluated in decode is true |
| ex_dst_addr | input | REG_AW | Destination register of the execute-stage instruction |
| ex_wr_en | input | 1 | Execute-stage instruction writes a register |
| mem_dst_addr | input | REG_AW | Destination register of the memory-stage instruction |
| mem_wr_en | input | 1 | Memory-stage instruction writes a register |
| pc_write | output | 1 | Program counter may update |
| ifid_write | output | 1 | Fetch/decode register may load |
| idex_bubble | output | 1 | Decode/execute register loads a no-op |
| ifid_flush | output | 1 | Fetch/decode register is cleared (taken branch) |

## Verification
The assertions check, on every cycle, the relations that depend only on current inputs. A live match in execute or memory must raise the hold. Register 0 and disabled writers must not. A flush never coincides with a hold and needs a taken branch. The hold always freezes both front-end enables. The stall durations (two cycles back to back, one with a gap) and the 15-cycle loop pattern come from instructions moving through the stages over time. Only the bench's pipeline model, driven by the block's own outputs, can show them.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    localparam int REG_AW_DEF  = 5;
    localparam int NUM_SRC_DEF = 2;
    localparam int NUM_PROD    = 2;   // execute and memory stages

    typedef enum logic [1:0] {
        ACT_RUN      = 2'd0,
        ACT_HOLD     = 2'd1,
        ACT_REDIRECT = 2'd2
    } hz_act_e;

    typedef struct packed {
        logic pc_we;
        logic fetch_we;
        logic bubble;
        logic squash;
    } hz_ctl_t;

    function automatic hz_ctl_t act_to_ctl(hz_act_e act);
        hz_ctl_t c;
        case (act)
            ACT_HOLD:     c = '{pc_we: 1'b0, fetch_we: 1'b0, bubble: 1'b1, squash: 1'b0};
            ACT_REDIRECT: c = '{pc_we: 1'b1, fetch_we: 1'b1, bubble: 1'b0, squash: 1'b1};
            default:      c = '{pc_we: 1'b1, fetch_we: 1'b1, bubble: 1'b0, squash: 1'b0};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/hzd_src_cmp.sv
module hzd_src_cmp #(
    parameter int REG_AW = 5,
    parameter int NPROD  = 2
) (
    input  logic                         src_use,
    input  logic [REG_AW-1:0]            src_addr,
    input  logic [NPROD-1:0][REG_AW-1:0] prod_dst,
    input  logic [NPROD-1:0]             prod_we,
    output logic                         conflict
);
    logic [NPROD-1:0] hit;

    for (genvar p = 0; p < NPROD; p++) begin : g_prod
        assign hit[p] = prod_we[p] && (prod_dst[p] != '0) && (prod_dst[p] == src_addr);
    end

    assign conflict = src_use && (|hit);
endmodule

// File: rtl/hzd_action_sel.sv
module hzd_action_sel
    import hzd_pkg::*;
(
    input  logic    stall,
    input  logic    is_branch,
    input  logic    br_taken,
    output hz_act_e act
);
    always_comb begin
        if (stall)                      act = ACT_HOLD;
        else if (is_branch && br_taken) act = ACT_REDIRECT;
        else                            act = ACT_RUN;
    end
endmodule

// File: rtl/hzd_ctl_drive.sv
module hzd_ctl_drive
    import hzd_pkg::*;
(
    input  hz_act_e act,
    output logic    pc_we,
    output logic    fetch_we,
    output logic    bubble,
    output logic    squash
);
    hz_ctl_t ctl;

    always_comb ctl = act_to_ctl(act);

    assign pc_we    = ctl.pc_we;
    assign fetch_we = ctl.fetch_we;
    assign bubble   = ctl.bubble;
    assign squash   = ctl.squash;
endmodule

// File: rtl/pipe_hazard_ctl.sv
module pipe_hazard_ctl
    import hzd_pkg::*;
#(
    parameter int REG_AW  = REG_AW_DEF,
    parameter int NUM_SRC = NUM_SRC_DEF
) (
    input  logic [NUM_SRC-1:0][REG_AW-1:0] id_src_addr,
    input  logic [NUM_SRC-1:0]             id_src_use,
    input  logic                           id_is_branch,
    input  logic                           id_br_taken,
    input  logic [REG_AW-1:0]              ex_dst_addr,
    input  logic                           ex_wr_en,
    input  logic [REG_AW-1:0]              mem_dst_addr,
    input  logic                           mem_wr_en,
    output logic                           pc_write,
    output logic                           ifid_write,
    output logic                           idex_bubble,
    output logic                           ifid_flush
);
    logic [NUM_PROD-1:0][REG_AW-1:0] prod_dst;
    logic [NUM_PROD-1:0]             prod_we;
    logic [NUM_SRC-1:0]              src_conflict;
    logic                            stall;
    hz_act_e                         act;

    // index 0 = execute (younger), index 1 = memory (older)
    assign prod_dst = {mem_dst_addr, ex_dst_addr};
    assign prod_we  = {mem_wr_en, ex_wr_en};

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        hzd_src_cmp #(
            .REG_AW (REG_AW),
            .NPROD  (NUM_PROD)
        ) u_cmp (
            .src_use  (id_src_use[s]),
            .src_addr (id_src_addr[s]),
            .prod_dst (prod_dst),
            .prod_we  (prod_we),
            .conflict (src_conflict[s])
        );
    end

    assign stall = |src_conflict;

    hzd_action_sel u_sel (
        .stall     (stall),
        .is_branch (id_is_branch),
        .br_taken  (id_br_taken),
        .act       (act)
    );

    hzd_ctl_drive u_drv (
        .act      (act),
        .pc_we    (pc_write),
        .fetch_we (ifid_write),
        .bubble   (idex_bubble),
        .squash   (ifid_flush)
    );
endmodule

// File: rtl/pipe_hazard_ctl_chk.sv
module pipe_hazard_ctl_chk #(
    parameter int REG_AW  = 5,
    parameter int NUM_SRC = 2
) (
    input logic [NUM_SRC-1:0][REG_AW-1:0] id_src_addr,
    input logic [NUM_SRC-1:0]             id_src_use,
    input logic                           id_is_branch,
    input logic                           id_br_taken,
    input logic [REG_AW-1:0]              ex_dst_addr,
    input logic                           ex_wr_en,
    input logic [REG_AW-1:0]              mem_dst_addr,
    input logic                           mem_wr_en,
    input logic                           pc_write,
    input logic                           ifid_write,
    input logic                           idex_bubble,
    input logic                           ifid_flush
);
    always_comb begin
        for (int s = 0; s < NUM_SRC; s++) begin
            if (id_src_use[s] && ex_wr_en && ex_dst_addr != '0 && id_src_addr[s] == ex_dst_addr)
                AST_EX_MATCH_HOLDS: assert (idex_bubble) else $error("ex match without hold"); // R1
            if (id_src_use[s] && mem_wr_en && mem_dst_addr != '0 && id_src_addr[s] == mem_dst_addr)
                AST_MEM_MATCH_HOLDS: assert (idex_bubble) else $error("mem match without hold"); // R2
        end
        if (ex_dst_addr == '0 && mem_dst_addr == '0)
            AST_ZERO_REG_FREE: assert (!idex_bubble) else $error("hold on register 0"); // R3
        if (!ex_wr_en && !mem_wr_en)
            AST_NO_WRITER_FREE: assert (!idex_bubble) else $error("hold without writer"); // R4
        if (id_src_use == '0)
            AST_NO_SOURCE_FREE: assert (!idex_bubble) else $error("hold without source"); // R4
        if (idex_bubble)
            AST_HOLD_FREEZES_FRONT: assert (!pc_write && !ifid_write) else $error("front moved in hold"); // R1
        AST_NO_FLUSH_IN_HOLD: assert (!(ifid_flush && idex_bubble)) else $error("flush during hold"); // R7
        if (ifid_flush)
            AST_FLUSH_NEEDS_TAKEN: assert (id_is_branch && id_br_taken) else $error("spurious flush"); // R8
        if (!idex_bubble && id_is_branch && id_br_taken)
            AST_TAKEN_REDIRECTS: assert (ifid_flush && pc_write) else $error("taken not flushed"); // R6
    end
endmodule

bind pipe_hazard_ctl pipe_hazard_ctl_chk #(
    .REG_AW  (REG_AW),
    .NUM_SRC (NUM_SRC)
) u_chk (
    .id_src_addr  (id_src_addr),
    .id_src_use   (id_src_use),
    .id_is_branch (id_is_branch),
    .id_br_taken  (id_br_taken),
    .ex_dst_addr  (ex_dst_addr),
    .ex_wr_en     (ex_wr_en),
    .mem_dst_addr (mem_dst_addr),
    .mem_wr_en    (mem_wr_en),
    .pc_write     (pc_write),
    .ifid_write   (ifid_write),
    .idex_bubble  (idex_bubble),
    .ifid_flush   (ifid_flush)
);

// File: tb/test_pipe_hazard_ctl.sv
module test_pipe_hazard_ctl;
    localparam int CLK_PERIOD = 10;
    localparam int AW  = 5;
    localparam int NS  = 2;

    typedef struct packed {
        logic       vld;
        logic [3:0] idx;
        logic       we;
        logic [4:0] rd;
        logic [1:0] rduse;
        logic [4:0] rs0;
        logic [4:0] rs1;
        logic       br;
    } ins_t;

    localparam ins_t NOP = '0;

    logic clk = 1'b0;
    logic [NS-1:0][AW-1:0] id_src_addr;
    logic [NS-1:0]         id_src_use;
    logic id_is_branch, id_br_taken, ex_wr_en, mem_wr_en;
    logic [AW-1:0] ex_dst_addr, mem_dst_addr;
    logic pc_write, ifid_write, idex_bubble, ifid_flush;

    int checks = 0;
    int errors = 0;

    ins_t prog [0:7];
    int   stall_cnt [0:7];

    always #(CLK_PERIOD/2) clk = ~clk;

    pipe_hazard_ctl #(.REG_AW(AW), .NUM_SRC(NS)) i_pipe_hazard_ctl (
        .id_src_addr(id_src_addr), .id_src_use(id_src_use),
        .id_is_branch(id_is_branch), .id_br_taken(id_br_taken),
        .ex_dst_addr(ex_dst_addr), .ex_wr_en(ex_wr_en),
        .mem_dst_addr(mem_dst_addr), .mem_wr_en(mem_wr_en),
        .pc_write(pc_write), .ifid_write(ifid_write),
        .idex_bubble(idex_bubble), .ifid_flush(ifid_flush)
    );

    function automatic logic [3:0] ref_out(ins_t id, ins_t ex, ins_t mem, logic taken);
        logic hz;
        logic [AW-1:0] src [0:1];
        hz = 1'b0;
        src[0] = id.rs0;
        src[1] = id.rs1;
        for (int s = 0; s < 2; s++) begin
            if (id.rduse[s] && ex.we && ex.rd != 0 && ex.rd == src[s]) hz = 1'b1;
            if (id.rduse[s] && mem.we && mem.rd != 0 && mem.rd == src[s]) hz = 1'b1;
        end
        // {pc_write, ifid_write, idex_bubble, ifid_flush}
        return {!hz, !hz, hz, !hz && id.br && taken};
    endfunction

    task automatic drive(ins_t id, ins_t ex, ins_t mem, logic taken);
        id_src_addr  = {id.rs1, id.rs0};
        id_src_use   = id.rduse;
        id_is_branch = id.br;
        id_br_taken  = taken;
        ex_dst_addr  = ex.rd;
        ex_wr_en     = ex.we;
        mem_dst_addr = mem.rd;
        mem_wr_en    = mem.we;
    endtask

    task automatic check(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic ins_t mk(int idx, logic we, int rd, logic [1:0] u, int a, int b, logic br);
        ins_t i;
        i.vld = 1'b1; i.idx = 4'(idx); i.we = we; i.rd = 5'(rd);
        i.rduse = u; i.rs0 = 5'(a); i.rs1 = 5'(b); i.br = br;
        return i;
    endfunction

    task automatic apply(string req, ins_t id, ins_t ex, ins_t mem, logic taken);
        @(posedge clk); #1;
        drive(id, ex, mem, taken);
        @(negedge clk);
        check(req, {pc_write, ifid_write, idex_bubble, ifid_flush}, ref_out(id, ex, mem, taken));
    endtask

    // Pipeline model driven by the block's own outputs
    task automatic run_prog(string req, int len, int niter, logic chk_period,
                            output int bub, output int fl);
        ins_t id, ex, mem;
        int pc, iter, cyc, last_lw;
        logic taken;
        id = NOP; ex = NOP; mem = NOP;
        pc = 0; iter = 0; cyc = 0; last_lw = -1; bub = 0; fl = 0;
        for (int k = 0; k < 8; k++) stall_cnt[k] = 0;
        while (!(pc >= len && !id.vld && !ex.vld && !mem.vld) && cyc < 1000) begin
            @(posedge clk); #1;
            taken = id.br && (iter < niter - 1);
            drive(id, ex, mem, taken);
            @(negedge clk);
            if (idex_bubble) begin
                bub++;
                if (id.vld) stall_cnt[id.idx]++;
            end
            if (ifid_flush) fl++;
            if (chk_period && id.vld && id.idx == 0 && !idex_bubble) begin
                if (last_lw >= 0) check({req, " loop period"}, cyc - last_lw, 15);
                last_lw = cyc;
            end
            if (id.br && !idex_bubble) iter++;
            mem = ex;
            if (idex_bubble) ex = NOP;
            else begin
                ex = id;
                if (ifid_flush) begin id = NOP; pc = 0; end
                else begin id = (pc < len) ? prog[pc] : NOP; pc++; end
            end
            cyc++;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int bub, fl;
        void'($urandom(32'd4242));
        drive(NOP, NOP, NOP, 1'b0);

        // R9 idle state
        apply("R9 idle", NOP, NOP, NOP, 1'b0);
        check("R9 idle outputs", {pc_write, ifid_write, idex_bubble, ifid_flush}, 4'b1100);
        // R1 execute match on slot 1
        apply("R1 ex match", mk(1,0,0,2'b10,0,7,0), mk(0,1,7,0,0,0,0), NOP, 1'b0);
        check("R1 hold", {pc_write, ifid_write, idex_bubble}, 3'b001);
        // R2 memory match on slot 0
        apply("R2 mem match", mk(1,0,0,2'b01,9,0,0), NOP, mk(0,1,9,0,0,0,0), 1'b0);
        check("R2 hold", idex_bubble, 1);
        // R3 register 0
        apply("R3 zero reg", mk(1,0,0,2'b11,0,0,0), mk(0,1,0,0,0,0,0), mk(0,1,0,0,0,0,0), 1'b0);
        check("R3 no hold", idex_bubble, 0);
        // R4 disabled writer and unused source
        apply("R4 we clear", mk(1,0,0,2'b11,6,6,0), mk(0,0,6,0,0,0,0), mk(0,0,6,0,0,0,0), 1'b0);
        check("R4 no hold we", idex_bubble, 0);
        apply("R4 unused", mk(1,0,0,2'b00,6,6,0), mk(0,1,6,0,0,0,0), NOP, 1'b0);
        check("R4 no hold use", idex_bubble, 0);
        // R6 taken branch
        apply("R6 taken", mk(5,0,0,2'b01,4,0,1), NOP, NOP, 1'b1);
        check("R6 redirect", {pc_write, ifid_write, idex_bubble, ifid_flush}, 4'b1101);
        // R7 taken but stalled
        apply("R7 stalled br", mk(5,0,0,2'b01,4,0,1), mk(4,1,4,0,0,0,0), NOP, 1'b1);
        check("R7 no flush", {idex_bubble, ifid_flush}, 2'b10);
        // R8 taken flag on non-branch, and not-taken branch
        apply("R8 non-branch", mk(1,0,0,2'b00,0,0,0), NOP, NOP, 1'b1);
        check("R8 no flush nb", ifid_flush, 0);
        apply("R8 not taken", mk(5,0,0,2'b01,4,0,1), NOP, NOP, 1'b0);
        check("R8 no flush nt", ifid_flush, 0);

        // random stimulus
        for (int n = 0; n < 400; n++) begin
            ins_t a, b, c;
            a = mk(1, 0, 0, 2'($urandom_range(0,3)), $urandom_range(0,3), $urandom_range(0,3), 1'($urandom_range(0,1)));
            b = mk(2, 1'($urandom_range(0,1)), $urandom_range(0,3), 0, 0, 0, 0);
            c = mk(3, 1'($urandom_range(0,1)), $urandom_range(0,3), 0, 0, 0, 0);
            apply(ref_out(a, b, c, 1'b1)[1] ? "R1 random hold" :
                  (ref_out(a, b, c, 1'b1)[0] ? "R6 random flush" : "R9 random run"),
                  a, b, c, 1'($urandom_range(0,1)));
        end

        // R10 loop: LW r1,(r2); ADDI r1; SW r1,(r2); ADDI r2; SUB r4,r3,r2; BNEZ r4
        prog[0] = mk(0,1,1,2'b01,2,0,0);
        prog[1] = mk(1,1,1,2'b01,1,0,0);
        prog[2] = mk(2,0,0,2'b11,2,1,0);
        prog[3] = mk(3,1,2,2'b01,2,0,0);
        prog[4] = mk(4,1,4,2'b11,3,2,0);
        prog[5] = mk(5,0,0,2'b01,4,0,1);
        run_prog("R10", 6, 3, 1'b1, bub, fl);
        check("R10 bubbles", bub, 24);
        check("R10 flushes", fl, 2);
        check("R5 adjacent load->add", stall_cnt[1], 6);
        check("R5 adjacent add->store", stall_cnt[2], 6);
        check("R5 adjacent sub->branch", stall_cnt[5], 6);
        check("R4 independent ptr add", stall_cnt[3], 0);

        // R5 one-between, R3 via register 0 in a pipeline
        prog[0] = mk(0,1,5,2'b00,0,0,0);
        prog[1] = mk(1,1,6,2'b00,0,0,0);
        prog[2] = mk(2,1,7,2'b11,5,5,0);
        prog[3] = mk(3,1,0,2'b00,0,0,0);
        prog[4] = mk(4,1,8,2'b01,0,0,0);
        run_prog("R5", 5, 1, 1'b0, bub, fl);
        check("R5 one-between", stall_cnt[2], 1);
        check("R3 reads r0 after write r0", stall_cnt[4], 0);
        check("R8 no branch no flush", fl, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule